// File: doc/BRIEF.md
# Masked Vector Gather Line-Step Unit

This block carries out a masked vector gather one memory line at a time. Sixteen lanes each hold a signed 32-bit index. The address of a lane is a common base plus its sign-extended index multiplied by a scale of 1, 2, 4 or 8. A 16-bit mask marks the lanes that still need data. In each step the unit takes the lowest-numbered pending lane and reads the single 64-byte line that holds its address. From that one response it fills every pending lane whose address lies in the same line, and then it clears the mask bits of those lanes.

A request starts with a one-cycle `start` pulse, which loads the base, indices, scale, mask and the current contents of the destination vector. If `auto_rep` is high, the unit keeps issuing steps until the mask is empty. If `auto_rep` is low, it stops after one step, and software continues by starting again with the returned mask and vector. Line reads use a simple port. The request stays raised, with a fixed line address, until a one-cycle response arrives that carries the whole line.

Top module: `masked_gather_stepper`

## Requirements
- R1: While reset is active and in the cycle after it, `mem_req`, `busy`, `step_done` and `done` are low and `mask_out` is zero.
- R2: Lane i uses the address `base_addr + sext(idx_i) * 2^scale_sel`, where `scale_sel` 0, 1, 2 and 3 select a scale of 1, 2, 4 and 8.
- R3: Each step requests the line of the pending lane with the lowest index. `mem_addr` is that lane's address with bits [5:0] forced to zero.
- R4: `mem_req` stays asserted with a stable `mem_addr` until `mem_rsp_valid` is seen. A step consumes exactly one line response.
- R5: Every pending lane whose line matches the requested line receives the 32-bit word `mem_rsp_data[w*32 +: 32]`, where w is bits [5:2] of its address.
- R6: In the cycle after a response, `step_done` pulses for one cycle and `mask_out` shows the filled lanes cleared. The mask never gains bits.
- R7: Lanes that are not pending, or whose line differs from the requested line, keep their previous value in `vec_out`.
- R8: A start with an all-zero mask issues no request and pulses `done` one cycle later. `vec_out` then equals the supplied `vec_in`.
- R9: With `auto_rep` high, steps repeat until the mask is zero. The number of steps equals the number of distinct 64-byte lines among the pending lanes. `done` pulses together with the last `step_done`.
- R10: With `auto_rep` low, the unit returns to idle after one step. `done` pulses only if that step emptied the mask.
- R11: Pending lanes with equal addresses, or with different addresses in the same line, are all filled in the same step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load operands and begin; ignored while busy |
| auto_rep | input | 1 | 1: repeat steps until the mask is empty |
| base_addr | input | ADDR_W | Byte base address |
| idx_vec | input | LANES*32 | Signed lane indices, lane i at [i*32 +: 32] |
| scale_sel | input | 2 | Index scale select (1, 2, 4, 8) |
| mask_in | input | LANES | Pending-lane mask |
| vec_in | input | LANES*32 | Initial destination vector contents |
| mem_req | output | 1 | Line read request |
| mem_addr | output | ADDR_W | 64-byte aligned line address |
| mem_rsp_valid | input | 1 | Line data valid |
| mem_rsp_data | input | 512 | Line data, word w at [w*32 +: 32] |
| vec_out | output | LANES*32 | Destination vector |
| mask_out | output | LANES | Remaining pending lanes |
| step_done | output | 1 | One-cycle pulse after each step |
| done | output | 1 | One-cycle pulse when the mask becomes empty |
| busy | output | 1 | A step is in flight |

## Verification
On the last step of a gather, the lane merge and mask clear coincide with the completion report, so `step_done` and `done` rise in the same cycle. The stimulus table provokes this at every entry: layouts that touch one line make it happen on the very first step, and layouts that touch sixteen lines make it happen only after many steps. The bench counts `step_done` pulses up to the cycle in which `done` appears and compares that count with its own count of distinct lines. It also checks that `mask_out` reads zero in that same sample.

// File: rtl/mg_pkg.sv
package mg_pkg;
    localparam int ELEM_W     = 32;
    localparam int IDX_W      = 32;
    localparam int LINE_BYTES = 64;
    localparam int OFS_W      = $clog2(LINE_BYTES);
    localparam int WORDS      = LINE_BYTES / (ELEM_W / 8);
    localparam int WSEL_W     = $clog2(WORDS);
    localparam int LINE_DW    = WORDS * ELEM_W;

    typedef enum logic [1:0] {SC_X1, SC_X2, SC_X4, SC_X8} scale_e;
    typedef enum logic {ST_IDLE, ST_FETCH} step_state_e;

    function automatic int unsigned scale_shift(scale_e s);
        return int'(s);
    endfunction
endpackage

// File: rtl/mg_addr_gen.sv
module mg_addr_gen
    import mg_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int ADDR_W = 48,
    localparam int LW    = ADDR_W - OFS_W
) (
    input  logic [ADDR_W-1:0]       base,
    input  logic [LANES*IDX_W-1:0]  idx_flat,
    input  scale_e                  scale,
    output logic [LANES*LW-1:0]     line_flat,
    output logic [LANES*WSEL_W-1:0] word_flat
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] sx;
        logic [ADDR_W-3:0] ea_w;
        assign idx  = idx_flat[g*IDX_W +: IDX_W];
        assign sx   = {{(ADDR_W-IDX_W){idx[IDX_W-1]}}, idx};
        assign ea_w = (ADDR_W-2)'((base + (sx << scale_shift(scale))) >> 2);
        assign line_flat[g*LW +: LW]         = ea_w[ADDR_W-3:WSEL_W];
        assign word_flat[g*WSEL_W +: WSEL_W] = ea_w[WSEL_W-1:0];
    end
endmodule

// File: rtl/mg_lane_pick.sv
module mg_lane_pick #(
    parameter int LANES = 16,
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic [LANES-1:0] pending,
    output logic [SEL_W-1:0] sel
);
    always_comb begin
        sel = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pending[i]) sel = SEL_W'(i);
        end
    end
endmodule

// File: rtl/mg_line_merge.sv
module mg_line_merge
    import mg_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int ADDR_W = 48,
    localparam int LW    = ADDR_W - OFS_W
) (
    input  logic [LANES*LW-1:0]     line_flat,
    input  logic [LANES*WSEL_W-1:0] word_flat,
    input  logic [LANES-1:0]        pending,
    input  logic [LW-1:0]           req_line,
    input  logic [LINE_DW-1:0]      line_data,
    input  logic [LANES*ELEM_W-1:0] vec_cur,
    output logic [LANES*ELEM_W-1:0] vec_nxt,
    output logic [LANES-1:0]        pending_nxt
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic              hit;
        logic [WSEL_W-1:0] w;
        assign hit = pending[g] && (line_flat[g*LW +: LW] == req_line);
        assign w   = word_flat[g*WSEL_W +: WSEL_W];
        assign vec_nxt[g*ELEM_W +: ELEM_W] =
            hit ? line_data[w*ELEM_W +: ELEM_W] : vec_cur[g*ELEM_W +: ELEM_W];
        assign pending_nxt[g] = pending[g] && !hit;
    end
endmodule

// File: rtl/masked_gather_stepper.sv
module masked_gather_stepper
    import mg_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int ADDR_W = 48
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    auto_rep,
    input  logic [ADDR_W-1:0]       base_addr,
    input  logic [LANES*32-1:0]     idx_vec,
    input  logic [1:0]              scale_sel,
    input  logic [LANES-1:0]        mask_in,
    input  logic [LANES*32-1:0]     vec_in,
    output logic                    mem_req,
    output logic [ADDR_W-1:0]       mem_addr,
    input  logic                    mem_rsp_valid,
    input  logic [511:0]            mem_rsp_data,
    output logic [LANES*32-1:0]     vec_out,
    output logic [LANES-1:0]        mask_out,
    output logic                    step_done,
    output logic                    done,
    output logic                    busy
);
    localparam int LW    = ADDR_W - OFS_W;
    localparam int SEL_W = $clog2(LANES);

    step_state_e                state_q;
    logic [ADDR_W-1:0]          base_q;
    logic [LANES*IDX_W-1:0]     idx_q;
    scale_e                     scale_q;
    logic [LANES-1:0]           mask_q;
    logic [LANES*ELEM_W-1:0]    vec_q;
    logic                       auto_q, step_done_q, done_q;

    logic [LANES*LW-1:0]        line_flat;
    logic [LANES*WSEL_W-1:0]    word_flat;
    logic [SEL_W-1:0]           sel;
    logic [LW-1:0]              req_line;
    logic [LANES*ELEM_W-1:0]    vec_nxt;
    logic [LANES-1:0]           mask_nxt;

    mg_addr_gen #(.LANES(LANES), .ADDR_W(ADDR_W)) u_addr (
        .base(base_q), .idx_flat(idx_q), .scale(scale_q),
        .line_flat(line_flat), .word_flat(word_flat)
    );

    mg_lane_pick #(.LANES(LANES)) u_pick (
        .pending(mask_q), .sel(sel)
    );

    assign req_line = line_flat[sel*LW +: LW];

    mg_line_merge #(.LANES(LANES), .ADDR_W(ADDR_W)) u_merge (
        .line_flat(line_flat), .word_flat(word_flat), .pending(mask_q),
        .req_line(req_line), .line_data(mem_rsp_data), .vec_cur(vec_q),
        .vec_nxt(vec_nxt), .pending_nxt(mask_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            base_q      <= '0;
            idx_q       <= '0;
            scale_q     <= SC_X1;
            mask_q      <= '0;
            vec_q       <= '0;
            auto_q      <= 1'b0;
            step_done_q <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            step_done_q <= 1'b0;
            done_q      <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        base_q  <= base_addr;
                        idx_q   <= idx_vec;
                        scale_q <= scale_e'(scale_sel);
                        mask_q  <= mask_in;
                        vec_q   <= vec_in;
                        auto_q  <= auto_rep;
                        if (mask_in == '0) done_q  <= 1'b1;
                        else               state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_rsp_valid) begin
                        vec_q       <= vec_nxt;
                        mask_q      <= mask_nxt;
                        step_done_q <= 1'b1;
                        if (mask_nxt == '0) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else if (!auto_q) begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q == ST_FETCH);
    assign mem_req   = busy;
    assign mem_addr  = {req_line, {OFS_W{1'b0}}};
    assign vec_out   = vec_q;
    assign mask_out  = mask_q;
    assign step_done = step_done_q;
    assign done      = done_q;
endmodule

// File: rtl/mg_checker.sv
module mg_checker #(
    parameter int LANES  = 16,
    parameter int ADDR_W = 48
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic                mem_req,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic                mem_rsp_valid,
    input logic [LANES*32-1:0] vec_out,
    input logic [LANES-1:0]    mask_out,
    input logic                step_done,
    input logic                done,
    input logic                busy
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!mem_req && !busy && !step_done && !done && mask_out == '0));

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_addr)));

    // R6
    step_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_rsp_valid) |=> step_done);

    // R6
    mask_shrink_chk: assert property (@(posedge clk) disable iff (rst)
        step_done |-> (((mask_out & ~$past(mask_out)) == '0) && (mask_out != $past(mask_out))));

    // R9
    done_empty_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (mask_out == '0 && !busy));

    // R7
    vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_rsp_valid && !start) |=> $stable(vec_out));
endmodule

bind masked_gather_stepper mg_checker #(.LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .vec_out(vec_out), .mask_out(mask_out),
    .step_done(step_done), .done(done), .busy(busy)
);

// File: tb/masked_gather_stepper_test.sv
module masked_gather_stepper_test;
    localparam int PERIOD = 10;
    localparam int LANES  = 16;
    localparam int AW     = 48;
    localparam int NCASE  = 8;

    localparam logic [AW-1:0] T_BASE [NCASE] = '{48'h1000, 48'h2000, 48'h3000, 48'h4000,
                                                 48'h5040, 48'h6000, 48'h7000, 48'h1_0000_0100};
    localparam int          T_IDX0 [NCASE] = '{0, 0, 0, -8, 3, 0, 0, 5};
    localparam int          T_STEP [NCASE] = '{1, 16, 2, 1, 0, 4, 2, 17};
    localparam logic [1:0]  T_SC   [NCASE] = '{2'd2, 2'd2, 2'd2, 2'd3, 2'd2, 2'd0, 2'd1, 2'd2};
    localparam logic [15:0] T_MSK  [NCASE] = '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hF0F0,
                                               16'h00FF, 16'hFFFF, 16'hAAAA, 16'h1234};

    logic clk = 0, rst = 1, start = 0, auto_rep = 0;
    logic [AW-1:0] base_addr = '0;
    logic [LANES*32-1:0] idx_vec = '0, vec_in = '0, vec_out;
    logic [1:0] scale_sel = '0;
    logic [LANES-1:0] mask_in = '0, mask_out;
    logic mem_req, mem_rsp_valid = 0, step_done, done, busy;
    logic [AW-1:0] mem_addr, first_addr;
    logic [511:0] mem_rsp_data = '0;

    int checks = 0, fails = 0, req_cnt = 0, steps = 0;
    logic got_done;

    masked_gather_stepper #(.LANES(LANES), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .start(start), .auto_rep(auto_rep), .base_addr(base_addr),
        .idx_vec(idx_vec), .scale_sel(scale_sel), .mask_in(mask_in), .vec_in(vec_in),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .vec_out(vec_out), .mask_out(mask_out),
        .step_done(step_done), .done(done), .busy(busy)
    );

    always #(PERIOD/2) clk = ~clk;

    // line memory: word at byte address a reads (a & ~3) ^ 5A000000
    always @(negedge clk) begin
        if (rst || mem_rsp_valid) begin
            mem_rsp_valid = 1'b0;
        end else if (mem_req) begin
            if (req_cnt == 0) first_addr = mem_addr;
            for (int w = 0; w < 16; w++)
                mem_rsp_data[w*32 +: 32] = (mem_addr[31:0] + 32'(w*4)) ^ 32'h5A00_0000;
            mem_rsp_valid = 1'b1;
            req_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] ea(input logic [AW-1:0] b, input int idx, input logic [1:0] sc);
        longint a;
        a = longint'(b) + (longint'(idx) <<< sc);
        return a[AW-1:0];
    endfunction

    function automatic logic [31:0] prev_word(input int i);
        return 32'hDEAD_0000 | 32'(i);
    endfunction

    task automatic run(input logic [AW-1:0] b, input int i0, input int st, input logic [1:0] sc,
                       input logic [15:0] m, input bit au, input logic [LANES*32-1:0] dst);
        @(negedge clk);
        base_addr = b; scale_sel = sc; mask_in = m; auto_rep = au; vec_in = dst;
        for (int i = 0; i < LANES; i++) idx_vec[i*32 +: 32] = 32'(i0 + i*st);
        req_cnt = 0; steps = 0; got_done = 0; start = 1;
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            start = 0;
            if (step_done) steps++;
            if (done) got_done = 1;
            if (done || (step_done && !au)) break;
        end
    endtask

    initial begin
        #(PERIOD*200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [LANES*32-1:0] dst, expv;
        logic [AW-1:0] ln [LANES];
        int nlines, low;
        bit seen;

        for (int i = 0; i < LANES; i++) dst[i*32 +: 32] = prev_word(i);

        repeat (3) @(negedge clk);
        // R1 reset state
        check(!mem_req && !busy && !step_done && !done && mask_out == 0, "R1 reset",
              {mem_req, busy, step_done, done, mask_out}, 0);
        @(negedge clk); rst = 0;
        @(negedge clk);
        check(!mem_req && mask_out == 0, "R1 after reset", {mem_req, mask_out}, 0);

        // table walk, auto mode: R2 R3 R4 R5 R7 R9 R11
        for (int t = 0; t < NCASE; t++) begin
            nlines = 0; low = -1; expv = dst;
            for (int i = 0; i < LANES; i++) begin
                logic [AW-1:0] a;
                a = ea(T_BASE[t], T_IDX0[t] + i*T_STEP[t], T_SC[t]);
                ln[i] = a & ~AW'(63);
                if (T_MSK[t][i]) begin
                    if (low < 0) low = i;
                    seen = 0;
                    for (int j = 0; j < i; j++)
                        if (T_MSK[t][j] && ln[j] == ln[i]) seen = 1;
                    if (!seen) nlines++;
                    expv[i*32 +: 32] = a[31:0] & ~32'd3 ^ 32'h5A00_0000;
                end
            end
            run(T_BASE[t], T_IDX0[t], T_STEP[t], T_SC[t], T_MSK[t], 1'b1, dst);
            check(got_done, "R9 done seen", 64'(got_done), 1);
            check(steps == nlines, "R9 step count vs distinct lines", 64'(steps), 64'(nlines));
            check(req_cnt == nlines, "R4 one line read per step", 64'(req_cnt), 64'(nlines));
            check(first_addr == ln[low], "R3 lowest lane line first", 64'(first_addr), 64'(ln[low]));
            check(mask_out == 0, "R6 mask cleared", 64'(mask_out), 0);
            for (int i = 0; i < LANES; i++)
                check(vec_out[i*32 +: 32] == expv[i*32 +: 32],
                      T_MSK[t][i] ? "R5 R2 R11 lane filled" : "R7 inactive lane kept",
                      64'(vec_out[i*32 +: 32]), 64'(expv[i*32 +: 32]));
        end

        // R8 zero mask: no request, done, vector as supplied
        run(48'h9000, 0, 1, 2'd2, 16'h0000, 1'b1, dst);
        check(req_cnt == 0, "R8 no request", 64'(req_cnt), 0);
        check(got_done && steps == 0, "R8 done without step", {got_done, 32'(steps)}, 64'h1_0000_0000);
        check(vec_out == dst, "R8 vector unchanged", vec_out[63:0], dst[63:0]);

        // R10 step mode: lanes 0 and 8 on different lines
        run(48'h8000, 0, 16, 2'd2, 16'h0101, 1'b0, dst);
        check(steps == 1 && !got_done, "R10 single step no done", {got_done, 32'(steps)}, 1);
        check(mask_out == 16'h0100, "R10 remaining mask", 64'(mask_out), 64'h0100);
        check(!busy && !mem_req, "R10 idle after step", {busy, mem_req}, 0);
        check(vec_out[31:0] == (32'h8000 ^ 32'h5A00_0000), "R10 lane0 filled",
              64'(vec_out[31:0]), 64'(32'h8000 ^ 32'h5A00_0000));
        check(vec_out[8*32 +: 32] == prev_word(8), "R7 lane8 kept", 64'(vec_out[8*32 +: 32]), 64'(prev_word(8)));
        expv = vec_out;
        run(48'h8000, 0, 16, 2'd2, mask_out, 1'b0, expv);
        check(steps == 1 && got_done, "R10 last step raises done", {got_done, 32'(steps)}, 64'h1_0000_0001);
        check(mask_out == 0, "R10 mask empty", 64'(mask_out), 0);
        check(vec_out[8*32 +: 32] == ((32'h8000 + 32'd512) ^ 32'h5A00_0000), "R10 lane8 filled",
              64'(vec_out[8*32 +: 32]), 64'((32'h8000 + 32'd512) ^ 32'h5A00_0000));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule